// File: doc/BRIEF.md
# Exception Vector Address Generator

When the core takes an interrupt or a trap, this block works out where execution resumes. It receives an 8-bit vector number, the vector area base register and two configuration bits. From these it produces the handler start address, a tag that says whether that address lies in instruction space or ROM space, and a one-cycle completion strobe. Deciding which exception wins and running the handler are left to other blocks.

Dispatch works in one of two ways. In table mode the block reads one word from a table at the aligned base, indexed by the vector number. The returned word becomes the handler address. In block mode the handler begins directly inside a fixed-size code block at the aligned base, and no memory access is made. A parameter sets the base alignment to 64 KB or 1 KB. A second parameter builds a table-only variant that ignores the mode bit. Vector numbers 0 to 63 belong to processor-defined exceptions and 64 to 255 are free for other use. The block treats every number in the range alike.

Top module: `excVecGen`

## Requirements
- R1: After reset, `idle` is 1, and `rdReq`, `handlerDone`, `handlerRom` and all bits of `handlerAddr` are 0.
- R2: The aligned base is `vecBase` with its low 16 bits cleared when `ALIGN_64K` is 1, and with its low 10 bits cleared when `ALIGN_64K` is 0. Those low bits have no effect on any address produced.
- R3: In table mode (`cfgFetch` = 1), an accepted request raises `rdReq` in the next cycle. `rdReq` stays high up to and including the cycle in which `rdValid` is sampled high. While `rdReq` is high, `rdAddr` equals aligned base + 4 × vector, taken modulo 2^32.
- R4: In table mode, `handlerAddr` takes the `rdData` sampled with `rdValid`. `handlerDone` is high in the cycle after that sample.
- R5: In block mode (`cfgFetch` = 0), no read is issued. `handlerAddr` is aligned base + 256 × vector, modulo 2^32, and `handlerDone` is high in the cycle after the accepted request.
- R6: `handlerRom` takes `cfgRom` on a block-mode completion (1 = ROM space, 0 = instruction space). It is 0 on a table-mode completion.
- R7: With `TABLE_ONLY` = 1, every request is handled in table mode whatever `cfgFetch` is.
- R8: A request is accepted only while `idle` is 1. `idle` is 0 from the cycle after acceptance through the `handlerDone` cycle, and `excReq` has no effect during that time.
- R9: `handlerDone` lasts exactly one cycle. `handlerAddr` and `handlerRom` keep their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception taken, sampled while idle |
| excVec | input | VEC_W | Vector number |
| vecBase | input | ADDR_W | Vector area base register |
| cfgFetch | input | 1 | 1 = table mode, 0 = block mode |
| cfgRom | input | 1 | Block-mode handler lies in ROM space |
| idle | output | 1 | Ready to accept a request |
| rdReq | output | 1 | Table word read request |
| rdAddr | output | ADDR_W | Table word address |
| rdValid | input | 1 | Read data valid |
| rdData | input | ADDR_W | Read data |
| handlerAddr | output | ADDR_W | Handler start address |
| handlerRom | output | 1 | Handler address space tag |
| handlerDone | output | 1 | Result valid strobe |

## Verification
A block-mode result is due one clock after the request edge. A table-mode read appears one clock after acceptance, and its result comes one clock after the edge that sees `rdValid`. The memory latency is varied from zero to several cycles. The bench keeps a cycle-accurate reference of each instance, stepped on the rising edge from the same inputs the design samples. It compares every output on the falling edge that follows, so each expected value is checked in the exact cycle in which it becomes due and in every cycle it must be held.

// File: rtl/excVecPkg.sv
package excVecPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } vecState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeTable;  // latch table word address
    logic takeBlock;  // latch direct block address and space tag
    logic takeData;   // latch fetched handler address
  } dpStrobe_t;

endpackage

// File: rtl/excVecCtrl.sv
module excVecCtrl
  import excVecPkg::*;
#(
  parameter bit TABLE_ONLY = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      excReq,
  input  logic      cfgFetch,
  input  logic      rdValid,
  output dpStrobe_t strobe,
  output logic      idle,
  output logic      rdReq,
  output logic      done
);

  vecState_t state, stateNext;
  logic      fetchMode;

  assign fetchMode = TABLE_ONLY | cfgFetch;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (excReq) begin
          if (fetchMode) begin
            strobe.takeTable = 1'b1;
            stateNext        = ST_FETCH;
          end else begin
            strobe.takeBlock = 1'b1;
            stateNext        = ST_DONE;
          end
        end
      end
      ST_FETCH: begin
        if (rdValid) begin
          strobe.takeData = 1'b1;
          stateNext       = ST_DONE;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign idle  = (state == ST_IDLE);
  assign rdReq = (state == ST_FETCH);
  assign done  = (state == ST_DONE);

  // R9: completion strobe is a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: read request held until data returns
  p_read_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> rdReq);

  // R5: block mode completes next cycle without a read
  p_block_direct_r5: assert property (@(posedge clk) disable iff (!rstN)
    (idle && excReq && !cfgFetch && (TABLE_ONLY == 1'b0)) |=> (done && !rdReq));

  // R8: a busy engine stays busy until its completion cycle
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && !done) |=> !idle);

endmodule

// File: rtl/excVecDp.sv
module excVecDp
  import excVecPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int VEC_W       = 8,
  parameter bit ALIGN_64K   = 1'b1,
  parameter int BLOCK_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [VEC_W-1:0]  excVec,
  input  logic [ADDR_W-1:0] vecBase,
  input  logic              cfgRom,
  input  logic [ADDR_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] handlerAddr,
  output logic              handlerRom
);

  localparam int ALIGN_BITS  = ALIGN_64K ? 16 : 10;
  localparam int TABLE_SHIFT = 2;
  localparam int BLOCK_SHIFT = $clog2(BLOCK_WORDS * 4);
  localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << ALIGN_BITS;

  logic [ADDR_W-1:0] alignedBase;
  logic [ADDR_W-1:0] vecWide;
  logic [ADDR_W-1:0] tableAddr;
  logic [ADDR_W-1:0] blockAddr;

  assign alignedBase = vecBase & BASE_MASK;
  assign vecWide     = ADDR_W'(excVec);
  assign tableAddr   = alignedBase + (vecWide << TABLE_SHIFT);
  assign blockAddr   = alignedBase + (vecWide << BLOCK_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr      <= '0;
      handlerAddr <= '0;
      handlerRom  <= 1'b0;
    end else begin
      if (strobe.takeTable) rdAddr <= tableAddr;
      if (strobe.takeBlock) begin
        handlerAddr <= blockAddr;
        handlerRom  <= cfgRom;
      end else if (strobe.takeData) begin
        handlerAddr <= rdData;
        handlerRom  <= 1'b0;
      end
    end
  end

  // R2: removing the vector offset leaves an aligned base
  p_block_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeBlock |=>
      (((handlerAddr - (ADDR_W'($past(excVec)) << BLOCK_SHIFT)) & ~BASE_MASK) == '0));

  p_table_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTable |=>
      (((rdAddr - (ADDR_W'($past(excVec)) << TABLE_SHIFT)) & ~BASE_MASK) == '0));

endmodule

// File: rtl/excVecGen.sv
module excVecGen
  import excVecPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int VEC_W       = 8,
  parameter bit ALIGN_64K   = 1'b1,
  parameter bit TABLE_ONLY  = 1'b0,
  parameter int BLOCK_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [VEC_W-1:0]  excVec,
  input  logic [ADDR_W-1:0] vecBase,
  input  logic              cfgFetch,
  input  logic              cfgRom,
  output logic              idle,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdData,
  output logic [ADDR_W-1:0] handlerAddr,
  output logic              handlerRom,
  output logic              handlerDone
);

  dpStrobe_t strobe;

  excVecCtrl #(
    .TABLE_ONLY(TABLE_ONLY)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .excReq  (excReq),
    .cfgFetch(cfgFetch),
    .rdValid (rdValid),
    .strobe  (strobe),
    .idle    (idle),
    .rdReq   (rdReq),
    .done    (handlerDone)
  );

  excVecDp #(
    .ADDR_W     (ADDR_W),
    .VEC_W      (VEC_W),
    .ALIGN_64K  (ALIGN_64K),
    .BLOCK_WORDS(BLOCK_WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .excVec     (excVec),
    .vecBase    (vecBase),
    .cfgRom     (cfgRom),
    .rdData     (rdData),
    .rdAddr     (rdAddr),
    .handlerAddr(handlerAddr),
    .handlerRom (handlerRom)
  );

  // R6: completion after a table read reports instruction space
  p_table_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    (handlerDone && $past(rdReq)) |-> !handlerRom);

  // R4: completion follows either returned data or a direct request
  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    handlerDone |-> ($past(rdReq && rdValid) || $past(idle && excReq)));

endmodule

// File: tb/excVecGen_bench.sv
module excVecGen_bench;

  localparam int N = 3;  // 0: 64K full, 1: 1K full, 2: 1K table-only

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic        excReq;
  logic [7:0]  excVec;
  logic [31:0] vecBase;
  logic        cfgFetch;
  logic        cfgRom;

  logic        idle    [N];
  logic        rdReq   [N];
  logic [31:0] rdAddr  [N];
  logic        rdValid [N];
  logic [31:0] rdData  [N];
  logic [31:0] hAddr   [N];
  logic        hRom    [N];
  logic        hDone   [N];

  for (genvar g = 0; g < N; g++) begin : g_dut
    excVecGen #(
      .ALIGN_64K (g == 0),
      .TABLE_ONLY(g == 2)
    ) u_excVecGen (
      .clk        (clk),
      .rstN       (rstN),
      .excReq     (excReq),
      .excVec     (excVec),
      .vecBase    (vecBase),
      .cfgFetch   (cfgFetch),
      .cfgRom     (cfgRom),
      .idle       (idle[g]),
      .rdReq      (rdReq[g]),
      .rdAddr     (rdAddr[g]),
      .rdValid    (rdValid[g]),
      .rdData     (rdData[g]),
      .handlerAddr(hAddr[g]),
      .handlerRom (hRom[g]),
      .handlerDone(hDone[g])
    );
  end

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  int memLat = 1;

  int          mState [N];
  logic [31:0] mRdAddr[N];
  logic [31:0] mAddr  [N];
  logic        mRom   [N];
  bit          mTab   [N];
  int          cnt    [N];

  function automatic logic [31:0] memWord(int i, logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF ^ 32'(i);
  endfunction

  function automatic logic [31:0] maskFor(int i);
    return (i == 0) ? 32'hFFFF_0000 : 32'hFFFF_FC00;
  endfunction

  task automatic chk(string tag, int i, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s inst %0d at %0t: actual %h expected %h", tag, i, $time, act, exp);
    end
  endtask

  // reference model, stepped on the same edge as the design
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rstN) begin
        mState[i] = 0; mRdAddr[i] = '0; mAddr[i] = '0; mRom[i] = 1'b0;
      end else begin
        case (mState[i])
          0: if (excReq) begin
               mTab[i] = (i == 2) || cfgFetch;
               if (mTab[i]) begin
                 mRdAddr[i] = (vecBase & maskFor(i)) + 32'(excVec) * 4;
                 mState[i]  = 1;
               end else begin
                 mAddr[i]  = (vecBase & maskFor(i)) + 32'(excVec) * 256;
                 mRom[i]   = cfgRom;
                 mState[i] = 2;
               end
             end
          1: if (rdValid[i]) begin
               mAddr[i] = rdData[i]; mRom[i] = 1'b0; mState[i] = 2;
             end
          default: mState[i] = 0;
        endcase
      end
    end
  end

  // compare on the falling edge, then play the memory
  always @(negedge clk) begin
    if (checking) begin
      for (int i = 0; i < N; i++) begin
        chk("R8", i, 32'(idle[i]),  32'(mState[i] == 0));
        chk("R3", i, 32'(rdReq[i]), 32'(mState[i] == 1));
        if (mState[i] == 1) chk("R2", i, rdAddr[i], mRdAddr[i]);
        chk("R9", i, 32'(hDone[i]), 32'(mState[i] == 2));
        chk((i == 2) ? "R7" : (mTab[i] ? "R4" : "R5"), i, hAddr[i], mAddr[i]);
        chk("R6", i, 32'(hRom[i]), 32'(mRom[i]));
      end
    end
    for (int i = 0; i < N; i++) begin
      if (rdReq[i] === 1'b1 && !rdValid[i]) begin
        if (cnt[i] >= memLat) begin
          rdValid[i] = 1'b1; rdData[i] = memWord(i, rdAddr[i]); cnt[i] = 0;
        end else begin
          cnt[i]++; rdData[i] = 32'hBAD0_0000 | 32'(i);
        end
      end else begin
        rdValid[i] = 1'b0; rdData[i] = 32'hBAD1_0000;
      end
    end
  end

  task automatic runExc(input logic [7:0] v, input logic [31:0] b, input logic f,
                        input logic r, input int lat, input int hold);
    @(negedge clk);
    memLat = lat; excVec = v; vecBase = b; cfgFetch = f; cfgRom = r; excReq = 1'b1;
    repeat (hold) @(negedge clk);
    excReq = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; excReq = 1'b0; excVec = '0; vecBase = '0; cfgFetch = 1'b0; cfgRom = 1'b0;
    for (int i = 0; i < N; i++) begin
      rdValid[i] = 1'b0; rdData[i] = '0; cnt[i] = 0; mTab[i] = 0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin  // R1 reset state
      chk("R1", i, 32'(idle[i]), 32'd1);
      chk("R1", i, 32'(rdReq[i]), 32'd0);
      chk("R1", i, 32'(hDone[i]), 32'd0);
      chk("R1", i, hAddr[i], 32'd0);
      chk("R1", i, 32'(hRom[i]), 32'd0);
    end
    rstN = 1'b1;
    @(negedge clk);
    checking = 1;
    runExc(8'd0,   32'h1234_5678, 1'b1, 1'b1, 2, 1);  // table, vector 0, rom ignored
    runExc(8'd63,  32'hABCD_EF01, 1'b0, 1'b1, 1, 1);  // block, ROM space
    runExc(8'd64,  32'h0F0F_A5FF, 1'b0, 1'b0, 1, 1);  // block, instruction space
    runExc(8'd255, 32'h8000_83FF, 1'b1, 1'b0, 0, 1);  // table, zero latency
    runExc(8'd255, 32'hFFFF_FFFF, 1'b0, 1'b1, 1, 1);  // block, address wraps
    runExc(8'd200, 32'h4444_4444, 1'b1, 1'b0, 4, 9);  // R8: request held while busy
    runExc(8'd17,  32'h0000_0400, 1'b0, 1'b0, 1, 5);  // R8: held block request
    runExc(8'd5,   32'h7654_3210, 1'b1, 1'b1, 5, 1);  // slow memory
    checking = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual still running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule